// File: doc/BRIEF.md
# Tiled Array Address Generator

This block walks a two-dimensional array held in a linear memory. It produces the element addresses that cut the array into repeated rectangular tiles. The tiling is described by an origin point, a fitting matrix and a paving matrix. The paving matrix places each tile's reference point from its repetition index. The fitting matrix places each element of the tile from its pattern index, relative to that reference point. Every coordinate wraps modulo the array extent on its axis. As a result, tiles that reach past an edge fold back into the array.

A controller loads the array shape, the pattern shape, the repetition-space shape, the origin and the eight signed coefficients, and then pulses `start`. The block then streams one address per accepted beat on a valid/ready output. Each beat carries tile-start and tile-end markers and the repetition coordinates. `out_valid` stays high and every output field is held until `out_ready` is seen high at a clock edge. The sink may stall for any number of cycles. A one-cycle `done` pulse closes the job. As one use, a 176x144 luma plane and two 88x72 chroma planes can each be cut into an 11x9 grid of tiles. The three planes give 99 repetitions, and each repetition gathers 384 elements in total.

Top module: `tile_addr_gen`

## Requirements
- R1: After reset `out_valid`, `done` and `busy` are 0.
- R2: For pattern index (pi,pj) of repetition (ri,rj), col = (org_x + pav_xi*ri + pav_xj*rj + fit_xi*pi + fit_xj*pj) mod arr_w and row = (org_y + pav_yi*ri + pav_yj*rj + fit_yi*pi + fit_yj*pj) mod arr_h. The result is the non-negative remainder, and `out_addr` = row*arr_w + col.
- R3: Beats are ordered with pi fastest, then pj, then ri, then rj. Each index counts from 0 to its extent minus 1, giving pat_w*pat_h*rep_w*rep_h beats per job.
- R4: `out_first` is 1 exactly when pi=0 and pj=0. `out_last` is 1 exactly when pi=pat_w-1 and pj=pat_h-1. `out_rep_i` and `out_rep_j` carry ri and rj.
- R5: While `out_valid`=1 and `out_ready`=0, the next cycle still has `out_valid`=1 and the same output fields. With `out_ready` held at 1, one beat is accepted per cycle.
- R6: `done` is 1 for exactly the one cycle after the edge that accepts the last beat. `busy` is 0 in that cycle.
- R7: Configuration is captured at the edge where `start`=1 and `busy`=0. Changes to the configuration inputs during a job do not alter the stream.
- R8: `start` while `busy`=1 is ignored: the running job continues without restarting.
- R9: If any of arr_w, arr_h, pat_w, pat_h, rep_w or rep_h is 0 at start, `done` is 1 in the next cycle and no beat is offered.
- R10: A 176x144 array with 16x16 patterns, an 11x9 repetition space, origin (0,0), fit_xi=fit_yj=1 and pav_xi=pav_yj=16 gives 99 tiles covering every element once. An 88x72 array with 8x8 patterns and steps of 8 does the same.
- R11: Coefficients are signed 8-bit values; negative and extreme values (-128, 127) wrap into the array per R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job when idle |
| arr_w | input | 12 | Array width (columns) |
| arr_h | input | 12 | Array height (rows) |
| pat_w | input | 12 | Pattern extent along first index |
| pat_h | input | 12 | Pattern extent along second index |
| rep_w | input | 12 | Repetition extent along first index |
| rep_h | input | 12 | Repetition extent along second index |
| org_x | input | 12 | Origin column |
| org_y | input | 12 | Origin row |
| fit_xi | input | 8 | Signed column step per pi |
| fit_xj | input | 8 | Signed column step per pj |
| fit_yi | input | 8 | Signed row step per pi |
| fit_yj | input | 8 | Signed row step per pj |
| pav_xi | input | 8 | Signed column step per ri |
| pav_xj | input | 8 | Signed column step per rj |
| pav_yi | input | 8 | Signed row step per ri |
| pav_yj | input | 8 | Signed row step per rj |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| out_valid | output | 1 | Address beat offered |
| out_ready | input | 1 | Sink accepts the beat |
| out_addr | output | 24 | Linear element address |
| out_first | output | 1 | First element of a tile |
| out_last | output | 1 | Last element of a tile |
| out_rep_i | output | 12 | Repetition index ri |
| out_rep_j | output | 12 | Repetition index rj |

## Verification
The assertions check several rules on every cycle. A stalled beat is held. An offered address stays inside the array, and repetition indices stay inside their space. The done pulse lasts one cycle and never coincides with a beat. The captured configuration cannot change while a job runs. The exact address values, their order across pattern and repetition indices, the wrap of negative coefficients, the full coverage of the luma and chroma planes, and the zero-dimension early finish are shown only by the bench's scenarios. The bench compares each accepted beat with a model of R2 and R3 under random back-pressure.

// File: rtl/tile_pkg.sv
package tile_pkg;
  localparam int TG_AXES = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tg_state_e;
endpackage

// File: rtl/tile_walk.sv
// Nested two-level index counter. It keeps running signed offsets on both
// array axes, so no multiplier is needed: idx0 steps fastest.
module tile_walk #(
  parameter int DIM_W  = 12,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 22
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     step,
  input  logic [DIM_W-1:0]         ext0,
  input  logic [DIM_W-1:0]         ext1,
  input  logic signed [COEF_W-1:0] cx0,
  input  logic signed [COEF_W-1:0] cx1,
  input  logic signed [COEF_W-1:0] cy0,
  input  logic signed [COEF_W-1:0] cy1,
  output logic [DIM_W-1:0]         idx0,
  output logic [DIM_W-1:0]         idx1,
  output logic signed [ACC_W-1:0]  off_x,
  output logic signed [ACC_W-1:0]  off_y,
  output logic                     wrap
);
  import tile_pkg::*;

  logic last0, last1;
  logic signed [COEF_W-1:0] c_in [TG_AXES];
  logic signed [COEF_W-1:0] c_out[TG_AXES];
  logic signed [ACC_W-1:0]  base_q[TG_AXES];
  logic signed [ACC_W-1:0]  off_q [TG_AXES];

  assign last0 = (idx0 == ext0 - DIM_W'(1));
  assign last1 = (idx1 == ext1 - DIM_W'(1));
  assign wrap  = last0 && last1;

  assign c_in[0]  = cx0;
  assign c_in[1]  = cy0;
  assign c_out[0] = cx1;
  assign c_out[1] = cy1;

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      idx0 <= '0;
      idx1 <= '0;
    end else if (step) begin
      if (last0) begin
        idx0 <= '0;
        idx1 <= last1 ? '0 : idx1 + DIM_W'(1);
      end else begin
        idx0 <= idx0 + DIM_W'(1);
      end
    end
  end

  for (genvar a = 0; a < TG_AXES; a++) begin : g_axis
    always_ff @(posedge clk) begin
      if (!rst_n || load) begin
        base_q[a] <= '0;
        off_q[a]  <= '0;
      end else if (step) begin
        if (last0) begin
          if (last1) begin
            base_q[a] <= '0;
            off_q[a]  <= '0;
          end else begin
            base_q[a] <= base_q[a] + ACC_W'(c_out[a]);
            off_q[a]  <= base_q[a] + ACC_W'(c_out[a]);
          end
        end else begin
          off_q[a] <= off_q[a] + ACC_W'(c_in[a]);
        end
      end
    end
  end

  assign off_x = off_q[0];
  assign off_y = off_q[1];

  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && wrap) |=> (idx0 == '0 && idx1 == '0 && off_x == '0 && off_y == '0)); // R3
endmodule

// File: rtl/tile_wrap.sv
// One axis: origin + repetition offset + pattern offset, reduced to [0, shape).
module tile_wrap #(
  parameter int DIM_W = 12,
  parameter int ACC_W = 22,
  parameter int SUM_W = 24
) (
  input  logic [DIM_W-1:0]        org,
  input  logic signed [ACC_W-1:0] rep_off,
  input  logic signed [ACC_W-1:0] pat_off,
  input  logic [DIM_W-1:0]        shape,
  output logic [DIM_W-1:0]        coord
);
  logic signed [SUM_W-1:0] org_s, shape_s, sum, rem, fixd;
  logic unused_hi;

  assign org_s   = $signed({{(SUM_W-DIM_W){1'b0}}, org});
  assign shape_s = $signed({{(SUM_W-DIM_W){1'b0}}, shape});
  assign sum     = org_s + SUM_W'(rep_off) + SUM_W'(pat_off);

  always_comb begin
    if (shape == '0) rem = '0;
    else             rem = sum % shape_s;
    fixd = (rem < 0) ? rem + shape_s : rem;
  end

  assign coord     = fixd[DIM_W-1:0];
  assign unused_hi = ^fixd[SUM_W-1:DIM_W];
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int DIM_W  = 12,
  parameter int COEF_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [DIM_W-1:0]         arr_w,
  input  logic [DIM_W-1:0]         arr_h,
  input  logic [DIM_W-1:0]         pat_w,
  input  logic [DIM_W-1:0]         pat_h,
  input  logic [DIM_W-1:0]         rep_w,
  input  logic [DIM_W-1:0]         rep_h,
  input  logic [DIM_W-1:0]         org_x,
  input  logic [DIM_W-1:0]         org_y,
  input  logic signed [COEF_W-1:0] fit_xi,
  input  logic signed [COEF_W-1:0] fit_xj,
  input  logic signed [COEF_W-1:0] fit_yi,
  input  logic signed [COEF_W-1:0] fit_yj,
  input  logic signed [COEF_W-1:0] pav_xi,
  input  logic signed [COEF_W-1:0] pav_xj,
  input  logic signed [COEF_W-1:0] pav_yi,
  input  logic signed [COEF_W-1:0] pav_yj,
  output logic                     busy,
  output logic                     done,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [2*DIM_W-1:0]       out_addr,
  output logic                     out_first,
  output logic                     out_last,
  output logic [DIM_W-1:0]         out_rep_i,
  output logic [DIM_W-1:0]         out_rep_j
);
  import tile_pkg::*;

  localparam int ACC_W  = DIM_W + COEF_W + 2;
  localparam int SUM_W  = ACC_W + 2;
  localparam int ADDR_W = 2 * DIM_W;

  tg_state_e state_q;
  logic      done_q;
  logic      capture, zero_dim, hs;

  logic [DIM_W-1:0] arr_w_q, arr_h_q, pat_w_q, pat_h_q, rep_w_q, rep_h_q;
  logic [DIM_W-1:0] org_x_q, org_y_q;
  logic signed [COEF_W-1:0] fxi_q, fxj_q, fyi_q, fyj_q;
  logic signed [COEF_W-1:0] pxi_q, pxj_q, pyi_q, pyj_q;

  logic [DIM_W-1:0] pat_i, pat_j;
  logic signed [ACC_W-1:0] pat_ox, pat_oy, rep_ox, rep_oy;
  logic pat_wrap, rep_wrap;

  logic [DIM_W-1:0]        org_a  [TG_AXES];
  logic [DIM_W-1:0]        shp_a  [TG_AXES];
  logic signed [ACC_W-1:0] rofs_a [TG_AXES];
  logic signed [ACC_W-1:0] pofs_a [TG_AXES];
  logic [DIM_W-1:0]        crd_a  [TG_AXES];

  assign busy      = (state_q == ST_RUN);
  assign out_valid = busy;
  assign done      = done_q;
  assign hs        = out_valid && out_ready;
  assign capture   = !busy && start;
  assign zero_dim  = (arr_w == '0) || (arr_h == '0) || (pat_w == '0) ||
                     (pat_h == '0) || (rep_w == '0) || (rep_h == '0);

  // Control: job sequencing and end-of-job pulse
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          if (zero_dim) done_q  <= 1'b1;
          else          state_q <= ST_RUN;
        end
        ST_RUN: if (hs && pat_wrap && rep_wrap) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Configuration snapshot, taken only when a job is accepted
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arr_w_q <= '0; arr_h_q <= '0; pat_w_q <= '0; pat_h_q <= '0;
      rep_w_q <= '0; rep_h_q <= '0; org_x_q <= '0; org_y_q <= '0;
      fxi_q <= '0; fxj_q <= '0; fyi_q <= '0; fyj_q <= '0;
      pxi_q <= '0; pxj_q <= '0; pyi_q <= '0; pyj_q <= '0;
    end else if (capture) begin
      arr_w_q <= arr_w; arr_h_q <= arr_h; pat_w_q <= pat_w; pat_h_q <= pat_h;
      rep_w_q <= rep_w; rep_h_q <= rep_h; org_x_q <= org_x; org_y_q <= org_y;
      fxi_q <= fit_xi; fxj_q <= fit_xj; fyi_q <= fit_yi; fyj_q <= fit_yj;
      pxi_q <= pav_xi; pxj_q <= pav_xj; pyi_q <= pav_yi; pyj_q <= pav_yj;
    end
  end

  tile_walk #(.DIM_W(DIM_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_pat (
    .clk(clk), .rst_n(rst_n), .load(capture), .step(hs),
    .ext0(pat_w_q), .ext1(pat_h_q),
    .cx0(fxi_q), .cx1(fxj_q), .cy0(fyi_q), .cy1(fyj_q),
    .idx0(pat_i), .idx1(pat_j), .off_x(pat_ox), .off_y(pat_oy), .wrap(pat_wrap)
  );

  tile_walk #(.DIM_W(DIM_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .load(capture), .step(hs && pat_wrap),
    .ext0(rep_w_q), .ext1(rep_h_q),
    .cx0(pxi_q), .cx1(pxj_q), .cy0(pyi_q), .cy1(pyj_q),
    .idx0(out_rep_i), .idx1(out_rep_j), .off_x(rep_ox), .off_y(rep_oy), .wrap(rep_wrap)
  );

  assign org_a[0]  = org_x_q;  assign org_a[1]  = org_y_q;
  assign shp_a[0]  = arr_w_q;  assign shp_a[1]  = arr_h_q;
  assign rofs_a[0] = rep_ox;   assign rofs_a[1] = rep_oy;
  assign pofs_a[0] = pat_ox;   assign pofs_a[1] = pat_oy;

  for (genvar a = 0; a < TG_AXES; a++) begin : g_wrap
    tile_wrap #(.DIM_W(DIM_W), .ACC_W(ACC_W), .SUM_W(SUM_W)) u_wrap (
      .org(org_a[a]), .rep_off(rofs_a[a]), .pat_off(pofs_a[a]),
      .shape(shp_a[a]), .coord(crd_a[a])
    );
  end

  assign out_addr  = ADDR_W'(crd_a[1]) * ADDR_W'(arr_w_q) + ADDR_W'(crd_a[0]);
  assign out_first = (pat_i == '0) && (pat_j == '0);
  assign out_last  = pat_wrap;

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_first) && $stable(out_rep_i) && $stable(out_rep_j))); // R5
  AST_ADDR_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr < ADDR_W'(arr_w_q) * ADDR_W'(arr_h_q))); // R2
  AST_REP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_rep_i < rep_w_q && out_rep_j < rep_h_q)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !busy)); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(arr_w_q) && $stable(pat_w_q) && $stable(rep_h_q) && $stable(fxi_q) && $stable(pyj_q)))); // R8
endmodule

// File: tb/sim_tile_addr_gen.sv
module sim_tile_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [11:0] arr_w, arr_h, pat_w, pat_h, rep_w, rep_h, org_x, org_y;
  logic signed [7:0] fit_xi, fit_xj, fit_yi, fit_yj, pav_xi, pav_xj, pav_yi, pav_yj;
  logic busy, done, out_valid, out_first, out_last;
  logic out_ready = 1'b0;
  logic [23:0] out_addr;
  logic [11:0] out_rep_i, out_rep_j;

  int total = 0, bad = 0, cycles = 0;
  int e_aw, e_ah, e_pw, e_ph, e_rw, e_rh, e_ox, e_oy;
  int e_fxi, e_fxj, e_fyi, e_fyj, e_pxi, e_pxj, e_pyi, e_pyj;
  bit stall_pend = 0;
  logic [23:0] stall_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .arr_w(arr_w), .arr_h(arr_h), .pat_w(pat_w), .pat_h(pat_h),
    .rep_w(rep_w), .rep_h(rep_h), .org_x(org_x), .org_y(org_y),
    .fit_xi(fit_xi), .fit_xj(fit_xj), .fit_yi(fit_yi), .fit_yj(fit_yj),
    .pav_xi(pav_xi), .pav_xj(pav_xj), .pav_yi(pav_yi), .pav_yj(pav_yj),
    .busy(busy), .done(done), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_first(out_first), .out_last(out_last),
    .out_rep_i(out_rep_i), .out_rep_j(out_rep_j)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wrapm(input int v, input int m);
    int r = v % m;
    if (r < 0) r += m;
    return r;
  endfunction

  function automatic int ref_addr(input int ri, input int rj, input int pi, input int pj);
    int c = wrapm(e_ox + e_pxi*ri + e_pxj*rj + e_fxi*pi + e_fxj*pj, e_aw);
    int r = wrapm(e_oy + e_pyi*ri + e_pyj*rj + e_fyi*pi + e_fyj*pj, e_ah);
    return r * e_aw + c;
  endfunction

  task automatic set_cfg(input int aw, ah, pw, ph, rw, rh, ox, oy,
                         input int fxi, fxj, fyi, fyj, pxi, pxj, pyi, pyj);
    arr_w = 12'(aw); arr_h = 12'(ah); pat_w = 12'(pw); pat_h = 12'(ph);
    rep_w = 12'(rw); rep_h = 12'(rh); org_x = 12'(ox); org_y = 12'(oy);
    fit_xi = 8'(fxi); fit_xj = 8'(fxj); fit_yi = 8'(fyi); fit_yj = 8'(fyj);
    pav_xi = 8'(pxi); pav_xj = 8'(pxj); pav_yi = 8'(pyi); pav_yj = 8'(pyj);
  endtask

  function automatic int rc();
    return int'($urandom_range(40)) - 20;
  endfunction

  // Wait for one accepted beat and compare it with the model (R2, R3, R4, R5)
  task automatic take(input int pct, input int ri, rj, pi, pj, input bit cov);
    bit got = 0;
    while (!got) begin
      out_ready = (int'($urandom_range(99)) < pct);
      #1;
      if (stall_pend) begin
        chk(out_valid && out_addr == stall_addr, "R5 held beat", int'(out_addr), int'(stall_addr));
        stall_pend = 0;
      end
      if (out_valid && out_ready) begin
        chk(int'(out_addr) == ref_addr(ri, rj, pi, pj), cov ? "R10 address" : "R2 R3 R11 address",
            int'(out_addr), ref_addr(ri, rj, pi, pj));
        chk(out_first == (pi == 0 && pj == 0), "R4 first", int'(out_first), int'(pi == 0 && pj == 0));
        chk(out_last == (pi == e_pw-1 && pj == e_ph-1), "R4 last", int'(out_last), int'(pi == e_pw-1 && pj == e_ph-1));
        chk(int'(out_rep_i) == ri && int'(out_rep_j) == rj, "R4 rep index",
            int'(out_rep_j)*4096 + int'(out_rep_i), rj*4096 + ri);
        got = 1;
      end else if (out_valid) begin
        stall_pend = 1;
        stall_addr = out_addr;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_job(input int pct, input bit disturb, input bit cov);
    int k = 0;
    e_aw = int'(arr_w); e_ah = int'(arr_h); e_pw = int'(pat_w); e_ph = int'(pat_h);
    e_rw = int'(rep_w); e_rh = int'(rep_h); e_ox = int'(org_x); e_oy = int'(org_y);
    e_fxi = int'(fit_xi); e_fxj = int'(fit_xj); e_fyi = int'(fit_yi); e_fyj = int'(fit_yj);
    e_pxi = int'(pav_xi); e_pxj = int'(pav_xj); e_pyi = int'(pav_yi); e_pyj = int'(pav_yj);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (e_aw == 0 || e_ah == 0 || e_pw == 0 || e_ph == 0 || e_rw == 0 || e_rh == 0) begin
      #1;
      chk(done == 1'b1 && out_valid == 1'b0, "R9 zero-dim finish", int'(done)*2 + int'(out_valid), 2);
      @(negedge clk); #1;
      chk(done == 1'b0 && out_valid == 1'b0, "R9 no beat after", int'(done)*2 + int'(out_valid), 0);
      return;
    end
    for (int rj = 0; rj < e_rh; rj++)
      for (int ri = 0; ri < e_rw; ri++)
        for (int pj = 0; pj < e_ph; pj++)
          for (int pi = 0; pi < e_pw; pi++) begin
            if (disturb && k == 3) begin
              start = 1'b1;  // R8: ignored while busy
              set_cfg(7, 5, 2, 2, 1, 1, 3, 3, 9, -9, 4, 4, 1, 2, 3, 4);  // R7: no effect
            end
            take(pct, ri, rj, pi, pj, cov);
            if (disturb && k == 3) start = 1'b0;
            k++;
          end
    #1;
    chk(done == 1'b1 && busy == 1'b0, "R6 done after last", int'(done)*2 + int'(busy), 2);
    @(negedge clk); #1;
    chk(done == 1'b0 && out_valid == 1'b0, "R6 single pulse", int'(done)*2 + int'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    set_cfg(4, 4, 2, 2, 2, 2, 0, 0, 1, 0, 0, 1, 2, 0, 0, 2);
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 0 && done == 0 && busy == 0, "R1 reset state",
        int'(out_valid) + int'(done) + int'(busy), 0);
    rst_n = 1'b1;

    // R10 luma plane, sink always ready (R5 one beat per cycle)
    set_cfg(176, 144, 16, 16, 11, 9, 0, 0, 1, 0, 0, 1, 16, 0, 0, 16);
    run_job(100, 0, 1);
    // R10 chroma plane with back-pressure
    set_cfg(88, 72, 8, 8, 11, 9, 0, 0, 1, 0, 0, 1, 8, 0, 0, 8);
    run_job(60, 0, 1);
    // R7 R8 disturbance while busy
    set_cfg(10, 6, 3, 2, 2, 2, 1, 2, 1, 0, 0, 1, 3, 1, 1, 3);
    run_job(70, 1, 0);
    // R11 negative and extreme coefficients with wrap
    set_cfg(13, 11, 3, 2, 3, 2, 12, 10, -128, 127, 127, -128, -1, -5, 7, -128);
    run_job(50, 0, 0);
    set_cfg(5, 3, 4, 4, 2, 3, 4, 2, -1, -2, -3, 1, -7, 6, -9, 2);
    run_job(80, 0, 0);
    // R9 zero dimensions
    set_cfg(8, 8, 0, 2, 2, 2, 0, 0, 1, 0, 0, 1, 2, 0, 0, 2);
    run_job(100, 0, 0);
    set_cfg(8, 8, 2, 2, 2, 0, 0, 0, 1, 0, 0, 1, 2, 0, 0, 2);
    run_job(100, 0, 0);
    set_cfg(0, 8, 2, 2, 2, 2, 0, 0, 1, 0, 0, 1, 2, 0, 0, 2);
    run_job(100, 0, 0);
    // single-element pattern and repetition space
    set_cfg(1, 1, 1, 1, 1, 1, 0, 0, 5, 5, 5, 5, 5, 5, 5, 5);
    run_job(100, 0, 0);
    // constrained random jobs
    for (int n = 0; n < 8; n++) begin
      set_cfg(1 + int'($urandom_range(39)), 1 + int'($urandom_range(39)),
              1 + int'($urandom_range(5)), 1 + int'($urandom_range(5)),
              1 + int'($urandom_range(4)), 1 + int'($urandom_range(4)),
              int'($urandom_range(60)), int'($urandom_range(60)),
              rc(), rc(), rc(), rc(), rc(), rc(), rc(), rc());
      run_job(30 + int'($urandom_range(70)), (n % 3) == 0, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule